// File: doc/BRIEF.md
# Serial Port Status Register with Armed Clearing

This block holds the event flags of a serial port in one 16-bit status word. The transmit side reports that its holding byte has moved into the shifter and that it has gone fully idle. The receive side reports a full receive register, an idle line, an overrun, and noise, framing and parity errors on a received word. A live receiver-busy level sits in the word beside these sticky flags. The serial engines send each event as a single-cycle set pulse. The flags drive the interrupt logic directly through a live flag output.

A processor clears the sticky flags in two steps. It first reads either byte of the status word, and then it reads or writes the data register. A per-bit snapshot taken at the status read decides which flags the later data access may clear. A flag that rises after the status read is therefore not in the snapshot and survives the data access, and software sees it on its next status read. The idle-line flag re-arms only after a new received word, so one idle period raises it only once.

Top module: `sstat_reg`

## Requirements
- R1: After a synchronous reset, `flags_o` is 16'h0300: transmit-empty (bit 8) and transmit-done (bit 9) are 1, and every other bit is 0.
- R2: A set pulse on `evt_set` for a sticky bit (bits 0 parity, 1 framing, 2 noise, 3 overrun, 4 receive-full, 5 idle, 8 transmit-empty, 9 transmit-done) makes that bit of `flags_o` 1 on the next cycle. The bit stays 1 through any data register access that has no earlier status read.
- R3: A data register access clears, on the next cycle, every flag that was 1 when the last status read took place. The access is a read or a write at address 2.
- R4: A flag that rises after the status read stays 1 through the following data access, and it needs a new status read before it can clear.
- R5: A read of either status byte arms the clear for all 16 bits. Address 0 is the high byte and address 1 is the low byte.
- R6: When a set pulse and a clear fall on the same bit in the same cycle, the bit ends up 1.
- R7: Set pulses for receive-full and any error bits in the same cycle all show together in `flags_o` on the next cycle.
- R8: Bit 6 of `flags_o` follows `rx_active` one cycle later, and the clearing handshake does not change it.
- R9: After the idle flag has been cleared by the handshake, idle set pulses are ignored until a receive-full set pulse has arrived.
- R10: `rd_data` returns the addressed status byte during a read of address 0 or 1 and returns 0 otherwise. A write to a status address changes no flag and arms nothing.
- R11: A data access empties the snapshot, so a second data access with no new status read clears nothing.
- R12: Set pulses on bits 7 and 10 to 15 have no effect, and those bits of `flags_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | 0 status high byte, 1 status low byte, 2 data register |
| rd_data | output | 8 | Status byte read data (combinational) |
| evt_set | input | 16 | Single-cycle set pulses from the serial engines, one per flag bit |
| rx_active | input | 1 | Live receiver-busy level |
| flags_o | output | 16 | Current flag word |

## Verification
The hardest case to reach is a flag that rises between the status read and the data access, because it needs a set pulse placed exactly in the cycle gap between two bus accesses. The bench places that pulse in the gap, and it also places a pulse in the same cycle as the clearing access. A behavioural model then confirms that only the snapshotted bits drop. The idle re-arm case needs a complete handshake followed by further idle pulses before and after a receive-full pulse, and the stimulus runs that sequence in order.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
   // kind of bus access seen in a cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_STAT = 2'd1,
      ACC_DATA = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/sstat_decode.sv
module sstat_decode #(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned ADR_HI   = 0,
   parameter int unsigned ADR_LO   = 1,
   parameter int unsigned ADR_DATA = 2
) (
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   output sstat_pkg::acc_kind_e  kind,
   output logic                  rd_hi,
   output logic                  rd_lo
);
   import sstat_pkg::*;

   logic hit_hi, hit_lo, hit_data;

   always_comb begin
      hit_hi   = (bus_addr == ADDR_W'(ADR_HI));
      hit_lo   = (bus_addr == ADDR_W'(ADR_LO));
      hit_data = (bus_addr == ADDR_W'(ADR_DATA));
      rd_hi    = bus_rd && hit_hi;
      rd_lo    = bus_rd && hit_lo;
      if ((bus_rd || bus_wr) && hit_data)
         kind = ACC_DATA;
      else if (rd_hi || rd_lo)
         kind = ACC_STAT;
      else
         kind = ACC_NONE;
   end
endmodule

// File: rtl/sstat_flag_bit.sv
module sstat_flag_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= RST_VAL;
      else if (set)
         q <= 1'b1;
      else if (clr)
         q <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set |=> q);                                             // R6
   AST_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (rst)
      $fell(q) |-> $past(clr));                               // R3
endmodule

// File: rtl/sstat_arm.sv
module sstat_arm #(
   parameter int unsigned          WORD_W = 16,
   parameter logic [WORD_W-1:0]    MASK   = '1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  sstat_pkg::acc_kind_e  kind,
   input  logic [WORD_W-1:0]     flags,
   output logic [WORD_W-1:0]     clr_vec
);
   import sstat_pkg::*;

   logic [WORD_W-1:0] snap_q;

   always_ff @(posedge clk) begin
      if (rst)
         snap_q <= '0;
      else if (kind == ACC_DATA)
         snap_q <= '0;
      else if (kind == ACC_STAT)
         snap_q <= flags & MASK;
   end

   assign clr_vec = (kind == ACC_DATA) ? snap_q : '0;

   AST_SNAP_FLUSH: assert property (@(posedge clk) disable iff (rst)
      (kind == ACC_DATA) |=> (snap_q == '0));                 // R11
   AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (kind == ACC_STAT) |=> (snap_q == $past(flags & MASK))); // R5
   AST_LATE_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flags & $past(flags & ~snap_q & MASK))
                == $past(flags & ~snap_q & MASK)));           // R4
endmodule

// File: rtl/sstat_idle_gate.sv
module sstat_idle_gate (
   input  logic clk,
   input  logic rst,
   input  logic full_set,
   input  logic idle_set,
   input  logic idle_clr,
   output logic ok
);
   always_ff @(posedge clk) begin
      if (rst)
         ok <= 1'b1;
      else if (full_set)
         ok <= 1'b1;
      else if (idle_clr && !(idle_set && ok))
         ok <= 1'b0;
   end
endmodule

// File: rtl/sstat_reg.sv
module sstat_reg #(
   parameter int unsigned             BYTE_W      = 8,
   parameter int unsigned             ADDR_W      = 2,
   parameter int unsigned             ADR_HI      = 0,
   parameter int unsigned             ADR_LO      = 1,
   parameter int unsigned             ADR_DATA    = 2,
   parameter logic [2*BYTE_W-1:0]     STICKY_MASK = 16'h033F,
   parameter logic [2*BYTE_W-1:0]     RESET_VAL   = 16'h0300,
   parameter int unsigned             LIVE_BIT    = 6,
   parameter int unsigned             IDLE_BIT    = 5,
   parameter int unsigned             FULL_BIT    = 4,
   parameter bit                      IDLE_REARM  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   output logic [BYTE_W-1:0]     rd_data,
   input  logic [2*BYTE_W-1:0]   evt_set,
   input  logic                  rx_active,
   output logic [2*BYTE_W-1:0]   flags_o
);
   import sstat_pkg::*;

   localparam int unsigned WORD_W = 2 * BYTE_W;

   // elaboration-time parameter checks
   if (ADR_HI == ADR_LO || ADR_HI == ADR_DATA || ADR_LO == ADR_DATA)
      $error("sstat_reg: bus addresses must be distinct");
   if (BYTE_W < 1)
      $error("sstat_reg: BYTE_W must be at least 1");
   if (LIVE_BIT >= WORD_W || IDLE_BIT >= WORD_W || FULL_BIT >= WORD_W)
      $error("sstat_reg: flag position outside the word");
   if (STICKY_MASK[LIVE_BIT])
      $error("sstat_reg: live bit cannot be sticky");
   if ((RESET_VAL & ~STICKY_MASK) != '0)
      $error("sstat_reg: reset value on a non-sticky bit");

   acc_kind_e         kind;
   logic              rd_hi, rd_lo;
   logic [WORD_W-1:0] flags;
   logic [WORD_W-1:0] clr_vec;
   logic [WORD_W-1:0] set_eff;
   logic              idle_ok;

   sstat_decode #(
      .ADDR_W(ADDR_W), .ADR_HI(ADR_HI), .ADR_LO(ADR_LO), .ADR_DATA(ADR_DATA)
   ) u_dec (
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .kind(kind), .rd_hi(rd_hi), .rd_lo(rd_lo)
   );

   sstat_arm #(.WORD_W(WORD_W), .MASK(STICKY_MASK)) u_arm (
      .clk(clk), .rst(rst), .kind(kind), .flags(flags), .clr_vec(clr_vec)
   );

   // idle re-arm variant chosen by parameter
   if (IDLE_REARM) begin : g_rearm
      sstat_idle_gate u_idle (
         .clk(clk), .rst(rst),
         .full_set(evt_set[FULL_BIT]),
         .idle_set(evt_set[IDLE_BIT]),
         .idle_clr(clr_vec[IDLE_BIT]),
         .ok(idle_ok)
      );
   end else begin : g_free
      assign idle_ok = 1'b1;
   end

   always_comb begin
      set_eff = evt_set & STICKY_MASK;
      if (!idle_ok)
         set_eff[IDLE_BIT] = 1'b0;
   end

   // one cell per bit: sticky flag, live level, or constant zero
   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         sstat_flag_bit #(.RST_VAL(RESET_VAL[i])) u_flag (
            .clk(clk), .rst(rst),
            .set(set_eff[i]), .clr(clr_vec[i]), .q(flags[i])
         );
      end else if (i == LIVE_BIT) begin : g_live
         logic live_q;
         always_ff @(posedge clk) begin
            if (rst) live_q <= 1'b0;
            else     live_q <= rx_active;
         end
         assign flags[i] = live_q;
      end else begin : g_zero
         assign flags[i] = 1'b0;
      end
   end

   always_comb begin
      if (rd_hi)
         rd_data = flags[WORD_W-1:BYTE_W];
      else if (rd_lo)
         rd_data = flags[BYTE_W-1:0];
      else
         rd_data = '0;
   end

   assign flags_o = flags;

   if (IDLE_REARM) begin : g_idle_chk
      AST_IDLE_HELD: assert property (@(posedge clk) disable iff (rst)
         (!idle_ok && !flags[IDLE_BIT]) |=> !flags[IDLE_BIT]);     // R9
   end
   AST_NO_DATA_NO_CLR: assert property (@(posedge clk) disable iff (rst)
      ((kind != ACC_DATA) && ((flags & STICKY_MASK) != '0))
         |=> ((flags & $past(flags & STICKY_MASK)) == $past(flags & STICKY_MASK))); // R2
endmodule

// File: tb/tb_sstat_reg.sv
`timescale 1ns/1ps
module tb_sstat_reg;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  rd_data;
   logic [15:0] evt_set = 16'h0;
   logic        rx_active = 1'b0;
   logic [15:0] flags_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_tag = "R1";

   // behavioural reference state
   logic [15:0] m_flags, m_snap;
   logic        m_idle_ok;
   logic [7:0]  last_rd;

   localparam logic [15:0] STICKY = 16'h033F;

   always #2.5 clk = ~clk;

   sstat_reg dut (
      .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .rd_data(rd_data), .evt_set(evt_set),
      .rx_active(rx_active), .flags_o(flags_o)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive, check read data, advance the model, check flags
   task automatic tick(input logic r, input logic w, input logic [1:0] a, input logic [15:0] s);
      logic [15:0] nf, setm, exp_rd;
      bit dacc, srd;
      bus_rd = r; bus_wr = w; bus_addr = a; evt_set = s;
      #1;
      exp_rd = 16'h0;
      if (r && a == 2'd0) exp_rd = {8'h0, m_flags[15:8]};
      else if (r && a == 2'd1) exp_rd = {8'h0, m_flags[7:0]};
      last_rd = rd_data;
      chk({"R10 rd_data ", cur_tag}, {8'h0, rd_data}, exp_rd);
      @(posedge clk);
      dacc = (r || w) && a == 2'd2;
      srd  = r && (a == 2'd0 || a == 2'd1);
      setm = s & STICKY;
      if (!m_idle_ok) setm[5] = 1'b0;
      nf = m_flags;
      if (dacc) nf = nf & ~m_snap;
      nf = nf | setm;
      nf[6] = rx_active;
      if (s[4]) m_idle_ok = 1'b1;
      else if (dacc && m_snap[5] && !setm[5]) m_idle_ok = 1'b0;
      if (dacc) m_snap = 16'h0;
      else if (srd) m_snap = m_flags & STICKY;
      m_flags = nf;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; evt_set = 16'h0;
      chk({"model ", cur_tag}, flags_o, m_flags);
   endtask

   task automatic idle_cyc();
      tick(1'b0, 1'b0, 2'd0, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired in %s", cur_tag);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_flags = 16'h0300; m_snap = 16'h0; m_idle_ok = 1'b1; last_rd = 8'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset flags", flags_o, 16'h0300);
      cur_tag = "R1";
      tick(1'b1, 1'b0, 2'd0, 16'h0);
      chk("R1 high byte read", {8'h0, last_rd}, 16'h0003);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      chk("R1 low byte read", {8'h0, last_rd}, 16'h0000);
      tick(1'b1, 1'b0, 2'd2, 16'h0);   // clears via R5 arm from previous read
      chk("R3 clear after status read", flags_o, 16'h0000);

      // R2: set and no clear without a status read
      cur_tag = "R2";
      tick(1'b0, 1'b0, 2'd0, 16'h0010);
      chk("R2 set visible", flags_o, 16'h0010);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      tick(1'b0, 1'b1, 2'd2, 16'h0);
      chk("R2 data access without status read", flags_o, 16'h0010);

      // R3: handshake clears
      cur_tag = "R3";
      tick(1'b0, 1'b0, 2'd0, 16'h0300);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      chk("R3 status low byte", {8'h0, last_rd}, 16'h0010);
      idle_cyc();
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      chk("R3 data read clears", flags_o, 16'h0000);

      // R5: high byte read arms low byte bits
      cur_tag = "R5";
      tick(1'b0, 1'b0, 2'd0, 16'h0301);
      tick(1'b1, 1'b0, 2'd0, 16'h0);
      chk("R5 high byte value", {8'h0, last_rd}, 16'h0003);
      tick(1'b0, 1'b1, 2'd2, 16'h0);
      chk("R5 all bits cleared", flags_o, 16'h0000);

      // R4: late flag survives
      cur_tag = "R4";
      tick(1'b0, 1'b0, 2'd0, 16'h0004);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b0, 1'b0, 2'd0, 16'h0002);
      tick(1'b0, 1'b1, 2'd2, 16'h0);
      chk("R4 late flag kept", flags_o, 16'h0002);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      chk("R4 cleared after new read", flags_o, 16'h0000);

      // R6 and R11
      cur_tag = "R6";
      tick(1'b0, 1'b0, 2'd0, 16'h0008);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b0, 1'b1, 2'd2, 16'h0008);
      chk("R6 set beats clear", flags_o, 16'h0008);
      cur_tag = "R11";
      tick(1'b0, 1'b1, 2'd2, 16'h0);
      chk("R11 empty snapshot clears nothing", flags_o, 16'h0008);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      chk("R11 clear after fresh read", flags_o, 16'h0000);

      // R7: word with errors
      cur_tag = "R7";
      tick(1'b0, 1'b0, 2'd0, 16'h0017);
      chk("R7 full and errors together", flags_o, 16'h0017);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      chk("R7 cleared", flags_o, 16'h0000);

      // R8: live busy level
      cur_tag = "R8";
      rx_active = 1'b1;
      idle_cyc();
      chk("R8 busy follows", flags_o, 16'h0040);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      chk("R8 busy unaffected by handshake", flags_o, 16'h0040);
      rx_active = 1'b0;
      idle_cyc();
      chk("R8 busy drops", flags_o, 16'h0000);

      // R9: idle re-arm
      cur_tag = "R9";
      tick(1'b0, 1'b0, 2'd0, 16'h0020);
      chk("R9 idle set", flags_o, 16'h0020);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);
      tick(1'b0, 1'b0, 2'd0, 16'h0020);
      chk("R9 idle blocked", flags_o, 16'h0000);
      tick(1'b0, 1'b0, 2'd0, 16'h0010);
      tick(1'b0, 1'b0, 2'd0, 16'h0020);
      chk("R9 idle re-armed by receive-full", flags_o, 16'h0030);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b0, 1'b1, 2'd2, 16'h0);

      // R10: write to status addresses arms nothing
      cur_tag = "R10";
      tick(1'b0, 1'b0, 2'd0, 16'h0008);
      tick(1'b0, 1'b1, 2'd1, 16'h0);
      tick(1'b0, 1'b1, 2'd0, 16'h0);
      tick(1'b0, 1'b1, 2'd2, 16'h0);
      chk("R10 status write does not arm", flags_o, 16'h0008);
      tick(1'b1, 1'b0, 2'd3, 16'h0);
      chk("R10 unmapped read", {8'h0, last_rd}, 16'h0000);
      tick(1'b1, 1'b0, 2'd1, 16'h0);
      tick(1'b1, 1'b0, 2'd2, 16'h0);

      // R12: unused bits
      cur_tag = "R12";
      tick(1'b0, 1'b0, 2'd0, 16'hFC80);
      chk("R12 unused bits stay zero", flags_o, 16'h0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule